// File: doc/BRIEF.md
# Lane-Striped Vector Arithmetic Unit

This block is a small vector execution engine built from four identical lanes. Each lane owns one 16-bit integer adder, one 16-bit integer multiplier and a private slice of an eight-register, sixty-four-element vector register file. Elements are dealt out round-robin: element i of any register sits in lane i mod 4, at local slot i/4 inside that lane. Because of this placement, each element operation finds both operands and its destination in its own lane, so the lanes share no data path at all.

One vector instruction is taken at a time. It carries an operation (add or multiply), a destination register, two source registers and a vector length from 1 to 64. The controller walks through the element groups one per cycle. In each group all four adders (for add) or all four multipliers (for multiply) work together. When the walk ends, the controller pulses done. An element access port reads or writes one element by register number and global element index, so that registers can be loaded and inspected while the unit is idle.

The controller is a three-state machine. IDLE waits for a valid issue. IDLE goes to RUN when an issue is accepted. RUN stays in RUN while the current group is not the last one, and goes to DONE after the last group. DONE always returns to IDLE after one cycle.

Top module: `vec_lane_unit`

## Requirements
- R1: Element i of a register lives in lane i mod 4 at local slot i/4. Writing any element through the access port and reading it back at the same register and global index returns the written value, for all 8 registers and all 64 indices.
- R2: Add (issue_op = 0) writes vd[i] = (vs1[i] + vs2[i]) mod 2^16.
- R3: Multiply (issue_op = 1) writes vd[i] = the low 16 bits of the two's-complement product vs1[i] * vs2[i].
- R4: Only elements with index below the vector length are written. Elements at or beyond it, and all other registers, keep their values.
- R5: done goes high exactly ceil(VL/4)+1 clock edges after the edge that accepts the instruction, counting the accepting edge as the first. It stays high for exactly one cycle.
- R6: busy is high from the cycle after acceptance through the done cycle, and low afterwards.
- R7: issue_valid while busy is ignored: no second run, no second done pulse, and the second destination is untouched.
- R8: When the destination equals a source, each element is computed from the old source values.
- R9: An access-port write (acc_en=1, acc_we=1) takes effect only while the unit is idle. A read (acc_en=1, acc_we=0) while idle loads acc_rdata at the next edge, and acc_rdata holds its value otherwise.
- R10: An issue with vector length 0 or above 64 is not accepted: busy stays low and no register changes.
- R11: After reset, busy, done and acc_rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction present |
| issue_op | input | 1 | 0 = add, 1 = multiply |
| issue_vd | input | 3 | Destination register |
| issue_vs1 | input | 3 | First source register |
| issue_vs2 | input | 3 | Second source register |
| issue_vl | input | 7 | Vector length, 1..64 accepted |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_en | input | 1 | Element access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 3 | Register number for access |
| acc_idx | input | 6 | Global element index for access |
| acc_wdata | input | 16 | Element write data |
| acc_rdata | output | 16 | Registered element read data |

## Verification
The bench drives inputs on falling edges and samples on falling edges. An access-port read is therefore due at the first falling edge after the rising edge that captures it. busy is checked at the falling edge after the accepting edge. done is counted falling edge by falling edge and must first appear after exactly ceil(VL/4)+1 rising edges. It must then be gone, together with busy, one edge later. Results are read back only after done, through the access port, and every element of the destination is compared with a reference model kept in the bench, across every vector length with both operations.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vlu_state_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } vlu_op_e;

endpackage

// File: rtl/vlu_alu.sv
module vlu_alu #(
    parameter int ELEM_W = 16
) (
    input  logic              op,
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    output logic [ELEM_W-1:0] res
);
    import vlu_pkg::*;

    logic [ELEM_W-1:0]          sum;
    logic signed [2*ELEM_W-1:0] prod;

    always_comb begin
        sum  = a + b;
        prod = $signed(a) * $signed(b);
        unique case (vlu_op_e'(op))
            OP_ADD:  res = sum;
            OP_MUL:  res = prod[ELEM_W-1:0];
            default: res = sum;
        endcase
    end

endmodule

// File: rtl/vlu_lane.sv
module vlu_lane #(
    parameter int ELEM_W = 16,
    parameter int NREGS  = 8,
    parameter int DEPTH  = 16,
    parameter int REG_AW = 3,
    parameter int LOC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              run_act,
    input  logic              op,
    input  logic [REG_AW-1:0] vd,
    input  logic [REG_AW-1:0] vs1,
    input  logic [REG_AW-1:0] vs2,
    input  logic [LOC_W-1:0]  grp,
    input  logic              ext_we,
    input  logic [REG_AW-1:0] ext_reg,
    input  logic [LOC_W-1:0]  ext_loc,
    input  logic [ELEM_W-1:0] ext_wdata,
    output logic [ELEM_W-1:0] ext_rdata
);
    localparam int ENTRIES = NREGS * DEPTH;

    logic [ELEM_W-1:0] slice_mem [ENTRIES];
    logic [ELEM_W-1:0] opa, opb, result;
    logic              lane_we;

    assign opa       = slice_mem[{vs1, grp}];
    assign opb       = slice_mem[{vs2, grp}];
    assign ext_rdata = slice_mem[{ext_reg, ext_loc}];
    assign lane_we   = run_en && run_act;

    vlu_alu #(.ELEM_W(ELEM_W)) u_alu (
        .op  (op),
        .a   (opa),
        .b   (opb),
        .res (result)
    );

    // Operands are read and the result is written at the same local slot in
    // one cycle, so an in-place operation always sees the old values.
    always_ff @(posedge clk) begin
        if (lane_we)
            slice_mem[{vd, grp}] <= result;
        else if (ext_we)
            slice_mem[{ext_reg, ext_loc}] <= ext_wdata;
    end

    // R9: the external write path never competes with an instruction run
    a_r9_no_ext_during_run: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> !ext_we);

endmodule

// File: rtl/vlu_ctrl.sv
module vlu_ctrl #(
    parameter int LANES  = 4,
    parameter int MAX_VL = 64,
    parameter int REG_AW = 3,
    parameter int VL_W   = 7,
    parameter int GRP_W  = 4,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              issue_op,
    input  logic [REG_AW-1:0] issue_vd,
    input  logic [REG_AW-1:0] issue_vs1,
    input  logic [REG_AW-1:0] issue_vs2,
    input  logic [VL_W-1:0]   issue_vl,
    output logic              busy,
    output logic              done,
    output logic              run_en,
    output logic              cur_op,
    output logic [REG_AW-1:0] cur_vd,
    output logic [REG_AW-1:0] cur_vs1,
    output logic [REG_AW-1:0] cur_vs2,
    output logic [GRP_W-1:0]  grp,
    output logic [LANES-1:0]  lane_act
);
    import vlu_pkg::*;

    vlu_state_e        state, state_nx;
    logic [VL_W-1:0]   vl_q;
    logic [GRP_W-1:0]  last_grp;
    logic              accept;
    logic              last_step;

    assign accept    = (state == ST_IDLE) && issue_valid &&
                       (issue_vl != '0) && (issue_vl <= VL_W'(MAX_VL));
    assign last_step = (grp == last_grp);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)    state_nx = ST_RUN;
            ST_RUN:  if (last_step) state_nx = ST_DONE;
            ST_DONE:                state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy   = 1'b0;
        done   = 1'b0;
        run_en = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN:  begin busy = 1'b1; run_en = 1'b1; end
            ST_DONE: begin busy = 1'b1; done   = 1'b1; end
            default: ;
        endcase
    end

    // Instruction fields and group counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_op   <= 1'b0;
            cur_vd   <= '0;
            cur_vs1  <= '0;
            cur_vs2  <= '0;
            vl_q     <= '0;
            last_grp <= '0;
            grp      <= '0;
        end else if (accept) begin
            cur_op   <= issue_op;
            cur_vd   <= issue_vd;
            cur_vs1  <= issue_vs1;
            cur_vs2  <= issue_vs2;
            vl_q     <= issue_vl;
            last_grp <= GRP_W'((issue_vl - VL_W'(1)) >> LANE_W);
            grp      <= '0;
        end else if (state == ST_RUN && !last_step) begin
            grp <= grp + GRP_W'(1);
        end
    end

    // A lane takes part in the current group only if its global index is below VL
    for (genvar l = 0; l < LANES; l++) begin : g_act
        assign lane_act[l] = ({1'b0, grp, LANE_W'(l)} < vl_q);
    end

    // R4: the group counter never runs past the last group of the instruction
    a_r4_grp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (grp <= last_grp));

    // R4: the first group always has lane 0 active
    a_r4_first_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && grp == '0) |-> lane_act[0]);

endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit #(
    parameter int LANES  = 4,
    parameter int NREGS  = 8,
    parameter int MAX_VL = 64,
    parameter int ELEM_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       issue_valid,
    input  logic                       issue_op,
    input  logic [$clog2(NREGS)-1:0]   issue_vd,
    input  logic [$clog2(NREGS)-1:0]   issue_vs1,
    input  logic [$clog2(NREGS)-1:0]   issue_vs2,
    input  logic [$clog2(MAX_VL):0]    issue_vl,
    output logic                       busy,
    output logic                       done,
    input  logic                       acc_en,
    input  logic                       acc_we,
    input  logic [$clog2(NREGS)-1:0]   acc_reg,
    input  logic [$clog2(MAX_VL)-1:0]  acc_idx,
    input  logic [ELEM_W-1:0]          acc_wdata,
    output logic [ELEM_W-1:0]          acc_rdata
);
    localparam int DEPTH  = MAX_VL / LANES;
    localparam int REG_AW = $clog2(NREGS);
    localparam int IDX_W  = $clog2(MAX_VL);
    localparam int LANE_W = $clog2(LANES);
    localparam int LOC_W  = IDX_W - LANE_W;
    localparam int VL_W   = IDX_W + 1;

    logic              run_en, cur_op;
    logic [REG_AW-1:0] cur_vd, cur_vs1, cur_vs2;
    logic [LOC_W-1:0]  grp;
    logic [LANES-1:0]  lane_act;
    logic [LANE_W-1:0] acc_lane;
    logic [LOC_W-1:0]  acc_loc;
    logic              acc_rd_ok;
    logic [ELEM_W-1:0] lane_rd [LANES];

    assign acc_lane  = acc_idx[LANE_W-1:0];
    assign acc_loc   = acc_idx[IDX_W-1:LANE_W];
    assign acc_rd_ok = acc_en && !acc_we && !busy;

    vlu_ctrl #(
        .LANES(LANES), .MAX_VL(MAX_VL), .REG_AW(REG_AW),
        .VL_W(VL_W), .GRP_W(LOC_W), .LANE_W(LANE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_valid(issue_valid),
        .issue_op   (issue_op),
        .issue_vd   (issue_vd),
        .issue_vs1  (issue_vs1),
        .issue_vs2  (issue_vs2),
        .issue_vl   (issue_vl),
        .busy       (busy),
        .done       (done),
        .run_en     (run_en),
        .cur_op     (cur_op),
        .cur_vd     (cur_vd),
        .cur_vs1    (cur_vs1),
        .cur_vs2    (cur_vs2),
        .grp        (grp),
        .lane_act   (lane_act)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic lane_ext_we;
        assign lane_ext_we = acc_en && acc_we && !busy && (acc_lane == LANE_W'(l));

        vlu_lane #(
            .ELEM_W(ELEM_W), .NREGS(NREGS), .DEPTH(DEPTH),
            .REG_AW(REG_AW), .LOC_W(LOC_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_en   (run_en),
            .run_act  (lane_act[l]),
            .op       (cur_op),
            .vd       (cur_vd),
            .vs1      (cur_vs1),
            .vs2      (cur_vs2),
            .grp      (grp),
            .ext_we   (lane_ext_we),
            .ext_reg  (acc_reg),
            .ext_loc  (acc_loc),
            .ext_wdata(acc_wdata),
            .ext_rdata(lane_rd[l])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         acc_rdata <= '0;
        else if (acc_rd_ok) acc_rdata <= lane_rd[acc_lane];
    end

    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done only occurs while busy, and busy drops right after it
    a_r6_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r6_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R10: busy only rises after a valid issue with a legal vector length
    a_r10_legal_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(issue_valid && issue_vl != '0 &&
                              issue_vl <= VL_W'(MAX_VL)));

    // R9: read data only changes after an idle read request
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd_ok |=> $stable(acc_rdata));

endmodule

// File: tb/vec_lane_unit_test.sv
module vec_lane_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0, issue_op = 1'b0;
    logic [2:0]  issue_vd = '0, issue_vs1 = '0, issue_vs2 = '0;
    logic [6:0]  issue_vl = '0;
    logic        busy, done;
    logic        acc_en = 1'b0, acc_we = 1'b0;
    logic [2:0]  acc_reg = '0;
    logic [5:0]  acc_idx = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [15:0] model [8][64];

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_lane_unit uut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_vd(issue_vd), .issue_vs1(issue_vs1), .issue_vs2(issue_vs2),
        .issue_vl(issue_vl), .busy(busy), .done(done),
        .acc_en(acc_en), .acc_we(acc_we), .acc_reg(acc_reg), .acc_idx(acc_idx),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int seed, input int i);
        int v;
        if (i == 5)  return 16'h7fff;
        if (i == 6)  return 16'h8000;
        if (i == 7)  return 16'hffff;
        v = seed * 40503 + i * 9973 + (i * i) * 31;
        return v[15:0];
    endfunction

    task automatic poke(input int r, input int i, input logic [15:0] v);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_reg = 3'(r); acc_idx = 6'(i); acc_wdata = v;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
        model[r][i] = v;
    endtask

    task automatic peek_check(input int r, input int i, input string req);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_reg = 3'(r); acc_idx = 6'(i);
        @(negedge clk);
        acc_en = 1'b0;
        check(acc_rdata === model[r][i], req, int'(acc_rdata), int'(model[r][i]));
    endtask

    // Issue one instruction, time done, update the model.
    // disturb=1 drives a second issue and a port write while busy (R7, R9).
    task automatic run_op(input bit op, input int vd, input int s1, input int s2,
                          input int vl, input bit disturb);
        int n;
        int groups;
        logic signed [31:0] p;
        logic [15:0] res [64];
        groups = (vl + 3) / 4;
        for (int i = 0; i < 64; i++) begin
            if (op) begin
                p = $signed({{16{model[s1][i][15]}}, model[s1][i]}) *
                    $signed({{16{model[s2][i][15]}}, model[s2][i]});
                res[i] = p[15:0];
            end else begin
                res[i] = 16'((32'(model[s1][i]) + 32'(model[s2][i])) % 65536);
            end
        end
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op; issue_vd = 3'(vd);
        issue_vs1 = 3'(s1); issue_vs2 = 3'(s2); issue_vl = 7'(vl);
        @(posedge clk);
        @(negedge clk);
        issue_valid = 1'b0;
        n = 1;
        check(busy === 1'b1, "R6 busy after accept", int'(busy), 1);
        while (done !== 1'b1 && n < 200) begin
            if (disturb && n == 2) begin
                issue_valid = 1'b1; issue_op = 1'b0; issue_vd = 3'(7);
                issue_vs1 = 3'(s1); issue_vs2 = 3'(s2); issue_vl = 7'd64;
                acc_en = 1'b1; acc_we = 1'b1; acc_reg = 3'(6); acc_idx = 6'd9;
                acc_wdata = 16'h1234;
            end
            if (disturb && n == 4) begin
                issue_valid = 1'b0; acc_en = 1'b0; acc_we = 1'b0;
            end
            if (n > 1) check(busy === 1'b1, "R6 busy while running", int'(busy), 1);
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        check(n == groups + 1, "R5 done latency", n, groups + 1);
        @(posedge clk);
        @(negedge clk);
        check(done === 1'b0, "R5 done one cycle", int'(done), 0);
        check(busy === 1'b0, "R6 busy low after done", int'(busy), 0);
        for (int i = 0; i < vl; i++) model[vd][i] = res[i];
        if (disturb) begin
            repeat (30) begin
                @(negedge clk);
                check(done === 1'b0, "R7 no second done", int'(done), 0);
            end
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int vd, s1, s2;
        #(CLK_PERIOD * 2 + 2);
        check(busy === 1'b0, "R11 busy reset", int'(busy), 0);
        check(done === 1'b0, "R11 done reset", int'(done), 0);
        check(acc_rdata === 16'h0, "R11 rdata reset", int'(acc_rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: fill every element and read it back
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 64; i++) poke(r, i, pat(r + 1, i));
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 64; i++) peek_check(r, i, "R1 roundtrip");

        // R2/R3/R4: sweep every vector length with both operations
        for (int op = 0; op < 2; op++) begin
            for (int vl = 1; vl <= 64; vl++) begin
                vd = (vl + op) % 8;
                s1 = (vd + 1) % 8;
                s2 = (vd + 3) % 8;
                for (int i = 0; i < 64; i++) poke(s1, i, pat(vl * 3 + op, i));
                run_op(bit'(op), vd, s1, s2, vl, 1'b0);
                for (int i = 0; i < 64; i++)
                    peek_check(vd, i, (i >= vl) ? "R4 tail untouched" :
                                      (op == 0 ? "R2 add" : "R3 mul"));
                peek_check(s2, vl - 1, "R4 source untouched");
            end
        end

        // R8: in-place operations
        for (int i = 0; i < 64; i++) poke(2, i, pat(99, i));
        run_op(1'b0, 2, 2, 2, 37, 1'b0);
        for (int i = 0; i < 64; i++) peek_check(2, i, "R8 in-place add");
        run_op(1'b1, 2, 2, 3, 64, 1'b0);
        for (int i = 0; i < 64; i++) peek_check(2, i, "R8 in-place mul");

        // R7/R9: issue and port write while busy are ignored
        run_op(1'b1, 4, 0, 1, 64, 1'b1);
        for (int i = 0; i < 64; i++) peek_check(4, i, "R7 result intact");
        for (int i = 0; i < 64; i++) peek_check(7, i, "R7 second vd untouched");
        peek_check(6, 9, "R9 busy write ignored");

        // R10: illegal vector lengths
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            issue_valid = 1'b1; issue_op = 1'b0; issue_vd = 3'(5);
            issue_vs1 = 3'(0); issue_vs2 = 3'(1); issue_vl = (k == 0) ? 7'd0 : 7'd65;
            @(negedge clk);
            issue_valid = 1'b0;
            check(busy === 1'b0, "R10 not accepted", int'(busy), 0);
            repeat (20) @(negedge clk);
            check(done === 1'b0, "R10 no done", int'(done), 0);
        end
        for (int i = 0; i < 64; i++) peek_check(5, i, "R10 vd untouched");

        // R9: read data holds when no read is requested
        peek_check(3, 10, "R9 read");
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_reg = 3'(3); acc_idx = 6'd11; acc_wdata = 16'hbeef;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
        check(acc_rdata === model[3][10], "R9 rdata hold", int'(acc_rdata), int'(model[3][10]));
        model[3][11] = 16'hbeef;
        peek_check(3, 11, "R9 idle write");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule